// File: doc/BRIEF.md
# Calibrated One-Second Tick Generator

This block turns a slow crystal clock of roughly 33 kHz into a strobe that fires once per second. The length of a second comes from a calibration word held inside the block. That word has three parts: an integer tick limit, a 4-bit fraction, and a fraction-enable bit. When the fraction is enabled, some seconds are lengthened by one crystal cycle, so the long-run average period can fall between two whole cycle counts.

Writing a new calibration word restarts the second. The next strobe then lands exactly one full period after the write. The running tick count is brought out as a port, so the position within the current second can be read at any time.

Top module: `sec_tick_gen`

## Requirements
- R1: After reset the tick count and the strobe are 0, and the calibration word holds 0x198233: limit 0x8233, fraction 9, fraction enabled. The first strobe after reset release comes 33332 cycles later.
- R2: Only bits 20:0 of a written calibration word are kept, and the bits above are ignored. Bits 15:0 are the limit, bits 19:16 the fraction, and bit 20 enables the fraction.
- R3: The tick count steps from 0 up to the limit. On the cycle after it leaves the limit, the strobe is high for one cycle and the count reads 0.
- R4: With the fraction enabled and fraction value F, a 4-bit accumulator adds F once per second. Each carry out lengthens the following second by one cycle, during which the count holds at the limit for two cycles. Any 16 consecutive seconds therefore last 16*(limit+1)+F cycles.
- R5: With the fraction disabled, every second lasts exactly limit+1 cycles, whatever the fraction field holds.
- R6: A calibration write clears the tick count, the accumulator and any pending lengthening. The next strobe is limit+1 cycles after the clock edge that captures the write.
- R7: A write in the same cycle as a wrap wins: no strobe follows that edge, and the count reads 0.
- R8: Apart from a restart, the count either rises by one per cycle or holds at the limit, and it never exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_word_i | input | 32 | Calibration word; bits above 20 ignored |
| cal_we_i | input | 1 | Calibration write strobe |
| sec_pulse_o | output | 1 | One-cycle seconds strobe |
| tick_cnt_o | output | 16 | Live tick count |

## Verification
The block is tried with the default word straight out of reset, which tells whether the reset value and limit are right. It is then tried with small limits and the fraction disabled, which tells plain division apart from accidental stretching. Two fraction values with the fraction enabled show over 16 seconds whether the carry counting adds exactly F cycles. A word whose upper bits are all set checks that those bits are masked. Writes landing mid-second and on the exact wrap cycle separate correct re-phasing and priority from a late or duplicated strobe.

// File: rtl/sec_tick_pkg.sv
package sec_tick_pkg;
  localparam int TICK_W = 16;
  localparam int FRAC_W = 4;
  localparam int CAL_W  = TICK_W + FRAC_W + 1;

  typedef struct packed {
    logic              frac_en;
    logic [FRAC_W-1:0] frac;
    logic [TICK_W-1:0] ticks;
  } cal_t;

  localparam cal_t CAL_RST = 21'h198233;
endpackage

// File: rtl/sec_cal_reg.sv
module sec_cal_reg
  import sec_tick_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] word_i,
  input  logic            we_i,
  output cal_t            cal_o
);
  cal_t cal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cal_q <= CAL_RST;
    else if (we_i) cal_q <= cal_t'(word_i[CAL_W-1:0]);
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/sec_frac_acc.sv
module sec_frac_acc
  import sec_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              second_i,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              stretch_o
);
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (clear_i) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (second_i) begin
      if (en_i) begin
        acc_q     <= sum[FRAC_W-1:0];
        stretch_q <= sum[FRAC_W];
      end else begin
        stretch_q <= 1'b0;
      end
    end
  end

  assign stretch_o = stretch_q;
endmodule

// File: rtl/sec_tick_ctr.sv
module sec_tick_ctr
  import sec_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [TICK_W-1:0] limit_i,
  input  logic              stretch_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              wrap_o,
  output logic              pulse_o
);
  logic [TICK_W-1:0] tick_q;
  logic              dwell_q;
  logic              pulse_q;
  logic              at_end;
  logic              wrap;

  assign at_end = (tick_q == limit_i);
  // stretched second: hold at the limit one extra cycle
  assign wrap   = at_end && (!stretch_i || dwell_q) && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      dwell_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (clear_i) begin
      tick_q  <= '0;
      dwell_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (wrap) begin
        tick_q  <= '0;
        dwell_q <= 1'b0;
      end else if (at_end) begin
        dwell_q <= 1'b1;
      end else begin
        tick_q  <= tick_q + 1'b1;
      end
    end
  end

  assign tick_o  = tick_q;
  assign wrap_o  = wrap;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen
  import sec_tick_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   cal_word_i,
  input  logic              cal_we_i,
  output logic              sec_pulse_o,
  output logic [TICK_W-1:0] tick_cnt_o
);
  cal_t cal_q;
  logic stretch;
  logic wrap;

  sec_cal_reg #(.IN_W(IN_W)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (cal_word_i),
    .we_i   (cal_we_i),
    .cal_o  (cal_q)
  );

  sec_frac_acc u_frac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cal_we_i),
    .second_i  (wrap),
    .en_i      (cal_q.frac_en),
    .frac_i    (cal_q.frac),
    .stretch_o (stretch)
  );

  sec_tick_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cal_we_i),
    .limit_i   (cal_q.ticks),
    .stretch_i (stretch),
    .tick_o    (tick_cnt_o),
    .wrap_o    (wrap),
    .pulse_o   (sec_pulse_o)
  );
endmodule

// File: rtl/sec_tick_gen_chk.sv
module sec_tick_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cal_we_i,
  input logic        sec_pulse_o,
  input logic [15:0] tick_cnt_o,
  input logic [15:0] limit_i
);
  AST_WRITE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_we_i |=> (tick_cnt_o == 16'd0 && !sec_pulse_o)); // R6
  AST_WRAP_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_we_i && tick_cnt_o == limit_i) |=> !sec_pulse_o); // R7
  AST_PULSE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> tick_cnt_o == 16'd0); // R3
  AST_PULSE_AFTER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> $past(tick_cnt_o) == $past(limit_i)); // R3
  AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_cnt_o <= limit_i); // R8
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_cnt_o != 16'd0 |-> (tick_cnt_o == $past(tick_cnt_o) + 16'd1 ||
                             tick_cnt_o == $past(tick_cnt_o))); // R8
endmodule

bind sec_tick_gen sec_tick_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cal_we_i    (cal_we_i),
  .sec_pulse_o (sec_pulse_o),
  .tick_cnt_o  (tick_cnt_o),
  .limit_i     (cal_q.ticks)
);

// File: tb/test_sec_tick_gen.sv
`timescale 1ns/1ps
module test_sec_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cal_word = '0;
  logic        cal_we = 1'b0;
  logic        pulse;
  logic [15:0] tick;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sec_tick_gen i_sec_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .cal_word_i(cal_word), .cal_we_i(cal_we),
    .sec_pulse_o(pulse), .tick_cnt_o(tick)
  );

  // behavioural reference
  int m_lim, m_frac, m_en, m_acc, m_str, m_tick, m_held, m_pulse;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lim = 'h8233; m_frac = 9; m_en = 1; m_acc = 0; m_str = 0;
      m_tick = 0; m_held = 0; m_pulse = 0;
    end else if (cal_we) begin
      m_lim = cal_word & 'hFFFF; m_frac = (cal_word >> 16) & 'hF;
      m_en = (cal_word >> 20) & 1; m_acc = 0; m_str = 0;
      m_tick = 0; m_held = 0; m_pulse = 0;
    end else if (m_tick == m_lim && m_str != 0 && m_held == 0) begin
      m_held = 1; m_pulse = 0;
    end else if (m_tick == m_lim) begin
      m_pulse = 1; m_tick = 0; m_held = 0;
      if (m_en != 0) begin
        m_str = (m_acc + m_frac) >= 16; m_acc = (m_acc + m_frac) % 16;
      end else m_str = 0;
    end else begin
      m_tick++; m_pulse = 0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 model tick", tick, m_tick);
    chk("R3 model pulse", pulse, m_pulse);
  end

  task automatic wait_pulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!pulse && n < 40000);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cal_word = w; cal_we = 1'b1;
    @(negedge clk); cal_we = 1'b0;
  endtask

  // drive a write at the current negedge, return strobe distance from it
  task automatic wr_now_measure(input logic [31:0] w, output int n);
    cal_word = w; cal_we = 1'b1; n = 0;
    @(negedge clk); cal_we = 1'b0; n = 1;
    while (!pulse && n < 40000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    int sum;
    int longs;
    #1;
    chk("R1 reset tick", tick, 0);
    chk("R1 reset pulse", pulse, 0);
    #44 rst_n = 1'b1;
    @(negedge clk);
    n = 1;
    while (!pulse && n < 40000) begin @(negedge clk); n++; end
    chk("R1 first default second", n, 33332);

    @(negedge clk);
    wr_now_measure(32'h0000_0009, n);
    chk("R6 write to strobe", n, 11);
    for (int i = 0; i < 3; i++) begin
      wait_pulse(n); chk("R5 plain period", n, 10);
    end

    @(negedge clk);
    wr_now_measure(32'hFFE0_0005, n);
    chk("R2 upper bits masked first", n, 7);
    for (int i = 0; i < 3; i++) begin
      wait_pulse(n); chk("R2 upper bits masked period", n, 6);
    end

    @(negedge clk);
    wr_now_measure(32'h000F_0004, n);
    chk("R6 write restarts", n, 6);
    for (int i = 0; i < 4; i++) begin
      wait_pulse(n); chk("R5 fraction field ignored when off", n, 5);
    end

    wr(32'h0014_0007);
    wait_pulse(n);
    sum = 0; longs = 0;
    for (int i = 0; i < 16; i++) begin
      wait_pulse(n); sum += n; if (n == 9) longs++;
    end
    chk("R4 frac=4 16-second total", sum, 132);
    chk("R4 frac=4 long seconds", longs, 4);

    wr(32'h0019_0003);
    wait_pulse(n);
    sum = 0;
    for (int i = 0; i < 16; i++) begin wait_pulse(n); sum += n; end
    chk("R4 frac=9 16-second total", sum, 73);

    wr(32'h0010_0006);
    wait_pulse(n);
    for (int i = 0; i < 3; i++) begin
      wait_pulse(n); chk("R4 frac=0 enabled period", n, 7);
    end

    wr(32'h0000_0005);
    wait_pulse(n);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R7 count at limit", tick, 5);
    wr_now_measure(32'h0000_0005, n);
    chk("R7 write on wrap suppresses strobe", n, 7);

    wr(32'h0000_0008);
    for (int i = 0; i < 4; i++) @(negedge clk);
    wr_now_measure(32'h0000_0008, n);
    chk("R6 mid-second re-phase", n, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule